// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Collision Policy

This block is a synchronous memory with one write port and one read port sharing a single clock. A write is stored at the rising edge when the write enable is high. A read is requested by raising the read enable with an address. The word appears on the output one cycle later, or two cycles later when the optional output stage is built.

When a read and a write hit the same address in the same cycle, a forwarding multiplexer in front of the first output register decides the result. A parameter selects one of three policies. Write-first returns the incoming word. Read-first returns the word stored before the write. No-change leaves the output as it was.

The optional second register sits after that multiplexer. It has its own clock enable and uses the block reset. A parameter chooses whether reset acts asynchronously or at the clock edge. A deasserted read enable loads zero into the first register instead of memory data.

Top module: `sdp_collision_ram`

## Requirements
- R1: A word written with `wr_en` high is returned for a later read of that address. It appears on `rd_data` 1 cycle after the read request when `PIPE`=0, and 2 cycles after when `PIPE`=1 with `out_ce` high.
- R2: With `MODE`=WR_FIRST, a read that collides with a write returns the write data. A collision is `wr_en`, `rd_en` and equal addresses in the same cycle.
- R3: With `MODE`=RD_FIRST, a colliding read returns the word held before the write. A later read of that address returns the new word.
- R4: With `MODE`=NO_CHANGE, a colliding read leaves the first output register at its previous value. The write is still stored.
- R5: A cycle with `rd_en` low loads zero into the first output register in every mode, including when a write hits the read address. The memory is unaffected.
- R6: With `PIPE`=1, `out_ce` low holds `rd_data`, and `out_ce` high loads the first register's value. With `PIPE`=0, `out_ce` has no effect.
- R7: While `rst` is high, every output register is zero and `rd_data` reads 0. With `RST_ASYNC`=1 the reset acts asynchronously, otherwise it acts at the clock edge.
- R8: A write and a read at different addresses in the same cycle is not a collision. The read returns the stored word of its own address.
- R9: A cycle with `wr_en` low leaves the memory unchanged, whatever `wr_data` and `wr_addr` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Active-high reset of the output registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read strobe; low forces zero into the first output register |
| rd_addr | input | AW | Read address |
| out_ce | input | 1 | Clock enable of the optional output stage |
| rd_data | output | DW | Read word |

## Verification
Three instances run side by side on the same stimulus: write-first with the output stage, read-first with the output stage, and no-change without it. Collisions are applied on purpose. A mode mix-up shows up immediately: a wrong design returns new data where old was expected, or changes an output that should hold. Reads with the enable low are placed on a colliding write, so a design that gives collision priority over zeroing returns data instead of zero. Runs of `out_ce` low catch an output stage that keeps loading, and near-miss addresses catch a comparator that matches too widely. A write with the enable low followed by a read catches a memory that writes unconditionally.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    typedef enum logic [1:0] {
        WR_FIRST  = 2'd0,
        RD_FIRST  = 2'd1,
        NO_CHANGE = 2'd2
    } coll_mode_e;
endpackage

// File: rtl/sdp_store.sv
module sdp_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] mem_q [DEPTH];

    // Storage array: written at the edge, read combinationally into the
    // collision stage, which registers the result.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/sdp_bypass.sv
module sdp_bypass
    import sdp_pkg::*;
#(
    parameter int         DW        = 8,
    parameter int         AW        = 7,
    parameter coll_mode_e MODE      = WR_FIRST,
    parameter bit         RST_ASYNC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] mem_word,
    output logic [DW-1:0] s1_data
);
    typedef struct packed {
        logic [DW-1:0] data;
    } s1_t;

    s1_t s1_d, s1_q;
    logic hit;

    assign hit = wr_en && rd_en && (wr_addr == rd_addr);

    always_comb begin
        s1_d = s1_q;
        if (!rd_en) begin
            s1_d.data = '0;
        end else if (hit) begin
            case (MODE)
                WR_FIRST:  s1_d.data = wr_data;
                RD_FIRST:  s1_d.data = mem_word;
                default:   s1_d.data = s1_q.data;
            endcase
        end else begin
            s1_d.data = mem_word;
        end
    end

    if (RST_ASYNC) begin : g_arst
        always_ff @(posedge clk or posedge rst) begin
            if (rst) s1_q <= '0;
            else     s1_q <= s1_d;
        end
    end else begin : g_srst
        always_ff @(posedge clk) begin
            if (rst) s1_q <= '0;
            else     s1_q <= s1_d;
        end
    end

    assign s1_data = s1_q.data;
endmodule

// File: rtl/sdp_outstage.sv
module sdp_outstage #(
    parameter int DW        = 8,
    parameter bit PIPE      = 1'b1,
    parameter bit RST_ASYNC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    if (PIPE) begin : g_pipe
        typedef struct packed {
            logic [DW-1:0] data;
        } p2_t;

        p2_t p2_d, p2_q;

        always_comb begin
            p2_d = p2_q;
            if (ce) p2_d.data = din;
        end

        if (RST_ASYNC) begin : g_arst
            always_ff @(posedge clk or posedge rst) begin
                if (rst) p2_q <= '0;
                else     p2_q <= p2_d;
            end
        end else begin : g_srst
            always_ff @(posedge clk) begin
                if (rst) p2_q <= '0;
                else     p2_q <= p2_d;
            end
        end

        assign dout = p2_q.data;
    end else begin : g_bypass
        logic unused_ctl;
        assign unused_ctl = ce ^ rst ^ clk;
        assign dout = din;
    end
endmodule

// File: rtl/sdp_collision_ram.sv
module sdp_collision_ram
    import sdp_pkg::*;
#(
    parameter int         DW        = 8,
    parameter int         DEPTH     = 128,
    parameter int         AW        = $clog2(DEPTH),
    parameter coll_mode_e MODE      = WR_FIRST,
    parameter bit         PIPE      = 1'b1,
    parameter bit         RST_ASYNC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          out_ce,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_word;
    logic [DW-1:0] s1_data;

    sdp_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (mem_word)
    );

    sdp_bypass #(.DW(DW), .AW(AW), .MODE(MODE), .RST_ASYNC(RST_ASYNC)) u_bypass (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .mem_word (mem_word),
        .s1_data  (s1_data)
    );

    sdp_outstage #(.DW(DW), .PIPE(PIPE), .RST_ASYNC(RST_ASYNC)) u_out (
        .clk  (clk),
        .rst  (rst),
        .ce   (out_ce),
        .din  (s1_data),
        .dout (rd_data)
    );
endmodule

// File: rtl/sdp_collision_ram_chk.sv
module sdp_collision_ram_chk
    import sdp_pkg::*;
#(
    parameter int         DW   = 8,
    parameter int         AW   = 7,
    parameter coll_mode_e MODE = WR_FIRST,
    parameter bit         PIPE = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          out_ce,
    input logic [DW-1:0] s1_data,
    input logic [DW-1:0] rd_data
);
    // R5: a read cycle with the enable low leaves zero in the first register
    p_rden_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (s1_data == '0));

    if (MODE == WR_FIRST) begin : g_wf
        p_wf_new_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && rd_en && wr_addr == rd_addr) |=> (s1_data == $past(wr_data)));
    end

    if (MODE == NO_CHANGE) begin : g_nc
        p_nc_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && rd_en && wr_addr == rd_addr) |=> $stable(s1_data));
    end

    if (PIPE) begin : g_pipe
        p_ce_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !out_ce |=> $stable(rd_data));
        p_pipe_load_r1: assert property (@(posedge clk) disable iff (rst)
            out_ce |=> (rd_data == $past(s1_data)));
    end else begin : g_flat
        p_flat_r6: assert property (@(posedge clk) disable iff (rst)
            1'b1 |-> (rd_data == s1_data));
    end
endmodule

bind sdp_collision_ram sdp_collision_ram_chk #(
    .DW(DW), .AW(AW), .MODE(MODE), .PIPE(PIPE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .out_ce  (out_ce),
    .s1_data (s1_data),
    .rd_data (rd_data)
);

// File: tb/tb_sdp_collision_ram.sv
module tb_sdp_collision_ram;
    import sdp_pkg::*;

    localparam int DW = 8;
    localparam int DEPTH = 128;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic out_ce = 1'b1;
    logic [DW-1:0] q_wf, q_rf, q_nc;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdp_collision_ram #(.DW(DW), .DEPTH(DEPTH), .MODE(WR_FIRST), .PIPE(1'b1), .RST_ASYNC(1'b1)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_ce(out_ce), .rd_data(q_wf));
    sdp_collision_ram #(.DW(DW), .DEPTH(DEPTH), .MODE(RD_FIRST), .PIPE(1'b1), .RST_ASYNC(1'b0)) dut_rf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_ce(out_ce), .rd_data(q_rf));
    sdp_collision_ram #(.DW(DW), .DEPTH(DEPTH), .MODE(NO_CHANGE), .PIPE(1'b0), .RST_ASYNC(1'b1)) dut_nc (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_ce(out_ce), .rd_data(q_nc));

    // Reference model: index 0 write-first, 1 read-first, 2 no-change
    logic [DW-1:0] mem_m [DEPTH];
    logic [DW-1:0] s1_m [3];
    logic [DW-1:0] p2_m [3];

    task automatic check(input string tag, input string inst,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h", tag, inst, got, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, step the model at the
    // rising edge, compare at the next falling edge.
    task automatic tick(input string tag, input logic r, input logic we,
                        input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic re, input logic [AW-1:0] ra, input logic ce);
        logic [DW-1:0] old;
        logic hit;
        logic [DW-1:0] n1 [3];
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra; out_ce = ce;
        old = mem_m[ra];
        hit = we && re && (wa == ra);
        for (int m = 0; m < 3; m++) begin
            if (r || !re)   n1[m] = '0;
            else if (!hit)  n1[m] = old;
            else if (m == 0) n1[m] = wd;
            else if (m == 1) n1[m] = old;
            else             n1[m] = s1_m[m];
        end
        @(posedge clk);
        for (int m = 0; m < 3; m++) begin
            p2_m[m] = r ? '0 : (ce ? s1_m[m] : p2_m[m]);
            s1_m[m] = n1[m];
        end
        if (we) mem_m[wa] = wd;
        @(negedge clk);
        check(tag, "wf", q_wf, p2_m[0]);
        check(tag, "rf", q_rf, p2_m[1]);
        check(tag, "nc", q_nc, s1_m[2]);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_reset();
        tick("R7 reset", 1'b1, 1'b0, '0, '0, 1'b0, '0, 1'b1);
        tick("R7 reset", 1'b1, 1'b1, 7'd3, 8'h55, 1'b1, 7'd3, 1'b1);
        check("R7 reset value", "wf", q_wf, 8'h00);
    endtask

    task automatic t_fill_read();
        for (int a = 0; a < DEPTH; a++)
            tick("R1 fill", 1'b0, 1'b1, AW'(a), DW'(a * 37 + 11), 1'b0, '0, 1'b1);
        for (int a = 0; a < 16; a++)
            tick("R1 read", 1'b0, 1'b0, '0, '0, 1'b1, AW'(a * 7), 1'b1);
        tick("R1 read last", 1'b0, 1'b0, '0, '0, 1'b1, AW'(DEPTH - 1), 1'b1);
        idle("R1 drain", 2);
    endtask

    task automatic t_collision();
        // same-cycle read and write, then a plain read of the same word
        tick("R2 R3 R4 collide", 1'b0, 1'b0, '0, '0, 1'b1, 7'd20, 1'b1);
        tick("R2 R3 R4 collide", 1'b0, 1'b1, 7'd20, 8'hA5, 1'b1, 7'd20, 1'b1);
        tick("R2 R3 R4 collide", 1'b0, 1'b1, 7'd20, 8'h3C, 1'b1, 7'd20, 1'b1);
        tick("R3 R4 after", 1'b0, 1'b0, '0, '0, 1'b1, 7'd20, 1'b1);
        tick("R2 R3 R4 top addr", 1'b0, 1'b1, 7'd127, 8'hF0, 1'b1, 7'd127, 1'b1);
        tick("R3 R4 after top", 1'b0, 1'b0, '0, '0, 1'b1, 7'd127, 1'b1);
        idle("R2 drain", 2);
    endtask

    task automatic t_rden();
        tick("R5 read", 1'b0, 1'b0, '0, '0, 1'b1, 7'd5, 1'b1);
        tick("R5 rden low", 1'b0, 1'b0, '0, '0, 1'b0, 7'd5, 1'b1);
        tick("R5 rden low write", 1'b0, 1'b1, 7'd5, 8'h77, 1'b0, 7'd5, 1'b1);
        tick("R5 readback", 1'b0, 1'b0, '0, '0, 1'b1, 7'd5, 1'b1);
        idle("R5 drain", 2);
    endtask

    task automatic t_ce();
        tick("R6 load", 1'b0, 1'b0, '0, '0, 1'b1, 7'd9, 1'b1);
        tick("R6 hold", 1'b0, 1'b0, '0, '0, 1'b1, 7'd10, 1'b0);
        tick("R6 hold", 1'b0, 1'b0, '0, '0, 1'b1, 7'd11, 1'b0);
        tick("R6 hold", 1'b0, 1'b0, '0, '0, 1'b0, 7'd11, 1'b0);
        tick("R6 release", 1'b0, 1'b0, '0, '0, 1'b1, 7'd12, 1'b1);
        idle("R6 drain", 2);
    endtask

    task automatic t_nohit();
        tick("R8 near", 1'b0, 1'b1, 7'd40, 8'h12, 1'b1, 7'd41, 1'b1);
        tick("R8 near", 1'b0, 1'b1, 7'd64, 8'h34, 1'b1, 7'd0, 1'b1);
        tick("R8 back", 1'b0, 1'b0, '0, '0, 1'b1, 7'd40, 1'b1);
        tick("R8 back", 1'b0, 1'b0, '0, '0, 1'b1, 7'd64, 1'b1);
        idle("R8 drain", 2);
    endtask

    task automatic t_wen_low();
        tick("R9 wen low", 1'b0, 1'b0, 7'd30, 8'hEE, 1'b1, 7'd30, 1'b1);
        tick("R9 readback", 1'b0, 1'b0, '0, '0, 1'b1, 7'd30, 1'b1);
        idle("R9 drain", 2);
    endtask

    task automatic t_reset_mid();
        tick("R7 mid", 1'b0, 1'b0, '0, '0, 1'b1, 7'd2, 1'b1);
        tick("R7 mid reset", 1'b1, 1'b0, '0, '0, 1'b1, 7'd3, 1'b1);
        check("R7 mid value", "rf", q_rf, 8'h00);
        tick("R7 resume", 1'b0, 1'b0, '0, '0, 1'b1, 7'd4, 1'b1);
        idle("R7 drain", 2);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int m = 0; m < 3; m++) begin
            s1_m[m] = '0;
            p2_m[m] = '0;
        end
        @(negedge clk);
        t_reset();
        t_fill_read();
        t_collision();
        t_rden();
        t_ce();
        t_nohit();
        t_wen_low();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule